// File: doc/BRIEF.md
# Two-of-Three Serial Pattern Detector

This block watches a one-bit serial stream and raises its detect output whenever exactly two of the three most recent bits are ones. The three bits are the bit presented in the current cycle and the two accepted bits before it. The output is a Mealy function, so the current input bit is part of the window and the detect output responds in the same cycle that bit is presented. A window of three ones does not count as a match.

The stored state is only the two previously accepted bits, which gives four states. A qualifier input marks the cycles that carry a real bit. On a qualified cycle the bit is evaluated and then shifted into the history. On an unqualified cycle the history is kept and the output stays low. A synchronous reset empties the history, so any missing earlier bits count as zeros. The window check is built as a multiplexer. The current bit selects whether the history must hold one 1 or two 1s.

Top module: `tpd_two_of_three`

## Requirements
- R1: On a cycle with `bit_vld` high, `detect_o` is 1 exactly when the number of ones among `bit_in` and the two previously accepted bits equals 2. The output is combinational in the current cycle.
- R2: A window of three ones (current bit 1 and both stored bits 1) gives `detect_o` = 0.
- R3: While `rst` is high at a rising clock edge, the stored history becomes all zeros. Right after reset, the stream 1,1 gives outputs 0 then 1.
- R4: On a cycle with `bit_vld` low, `detect_o` is 0 and the history does not change. A stream broken by idle cycles gives the same outputs on its qualified cycles as the same stream without the gaps.
- R5: With history cleared, the qualified stream 0,1,1,0,1,1,1,0,0 gives the outputs 0,0,1,1,1,1,0,1,0.
- R6: Each qualified bit becomes the newest stored bit at the next rising edge, and the oldest stored bit is dropped.
- R7: A reset applied in the middle of a stream discards all earlier bits. The first qualified bit after it is judged against zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears history |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | High when `bit_in` carries a bit to consume |
| detect_o | output | 1 | High when the current window holds exactly two ones |

## Verification
The embedded properties check on every cycle that the output matches the ones count of the live window, that an all-ones window and an idle cycle both give a low output, and that the history shifts on qualified cycles, holds on idle ones and clears on reset. Some behaviours need whole sequences and can only be shown by the bench scenarios. These are the worked example stream, equivalence of a gapped stream with the same stream without gaps, and the post-reset behaviour after a mid-stream reset. The bench tracks these against its own window model over directed and random streams.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
    // Width of the sliding window, including the live input bit.
    localparam int WIN_BITS    = 3;
    // Ones count that constitutes a match.
    localparam int MATCH_ONES  = 2;
    // Stored history excludes the live bit.
    localparam int HIST_BITS   = WIN_BITS - 1;
endpackage

// File: rtl/tpd_history.sv
module tpd_history #(
    parameter int HIST_W = tpd_pkg::HIST_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic [HIST_W-1:0] hist_o
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;   // bit 0 is the newest accepted bit
    } hist_s;

    hist_s             st_d, st_q;
    logic [HIST_W-1:0] shifted;

    generate
        if (HIST_W == 1) begin : g_single
            assign shifted = bit_in;
        end else begin : g_multi
            assign shifted = {st_q.bits[HIST_W-2:0], bit_in};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (bit_vld) begin
            st_d.bits = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_o = st_q.bits;

    // R4
    hist_hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(hist_o));

    // R6
    hist_shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> hist_o[0] == $past(bit_in));

    // R3
    hist_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> hist_o == '0);
endmodule

// File: rtl/tpd_window_eval.sv
module tpd_window_eval #(
    parameter int HIST_W = tpd_pkg::HIST_BITS,
    parameter int MATCH  = tpd_pkg::MATCH_ONES
) (
    input  logic [HIST_W-1:0] hist_i,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic              hit_o
);
    localparam int CNT_W = $clog2(HIST_W + 2);

    logic [CNT_W-1:0] hist_ones;
    logic             need_low;   // history count that matches when live bit is 1
    logic             need_high;  // history count that matches when live bit is 0

    always_comb begin
        hist_ones = '0;
        for (int i = 0; i < HIST_W; i++) begin
            hist_ones = hist_ones + CNT_W'(hist_i[i]);
        end
    end

    assign need_low  = (hist_ones == CNT_W'(MATCH - 1));
    assign need_high = (hist_ones == CNT_W'(MATCH));

    // Live bit steers a 2:1 mux between the two history conditions.
    always_comb begin
        hit_o = 1'b0;
        if (bit_vld) begin
            hit_o = bit_in ? need_low : need_high;
        end
    end
endmodule

// File: rtl/tpd_two_of_three.sv
module tpd_two_of_three #(
    parameter int HIST_W = tpd_pkg::HIST_BITS,
    parameter int MATCH  = tpd_pkg::MATCH_ONES
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic detect_o
);
    logic [HIST_W-1:0] hist;

    tpd_history #(.HIST_W(HIST_W)) i_history (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .hist_o  (hist)
    );

    tpd_window_eval #(.HIST_W(HIST_W), .MATCH(MATCH)) i_eval (
        .hist_i  (hist),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .hit_o   (detect_o)
    );

    // R1
    det_count_match_chk: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> detect_o == ($countones({hist, bit_in}) == MATCH));

    // R2
    det_all_ones_low_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && bit_in && (&hist)) |-> !detect_o);

    // R4
    det_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |-> !detect_o);
endmodule

// File: tb/test_tpd_two_of_three.sv
module test_tpd_two_of_three;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic detect_o;

    int checks = 0;
    int errors = 0;
    logic [1:0] mdl_hist = 2'b00;   // bit 0 newest
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpd_two_of_three i_tpd_two_of_three (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .detect_o(detect_o)
    );

    function automatic logic model_out(input logic [1:0] h, input logic b, input logic v);
        int ones;
        ones = int'(h[0]) + int'(h[1]) + int'(b);
        return v && (ones == 2);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: detect_o actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive on falling edge, check before rising edge, update model at edge.
    task automatic step(input logic b, input logic v, input string req);
        @(negedge clk);
        bit_in  = b;
        bit_vld = v;
        #1;
        check(req, detect_o, model_out(mdl_hist, b, v));
        @(posedge clk);
        if (v) mdl_hist = {mdl_hist[0], b};
    endtask

    task automatic step_exp(input logic b, input logic exp, input string req);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        #1;
        check(req, detect_o, exp);
        @(posedge clk);
        mdl_hist = {mdl_hist[0], b};
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        bit_vld = 1'b1;
        bit_in = 1'b1;
        repeat (cycles) @(posedge clk);
        mdl_hist = 2'b00;
        @(negedge clk);
        rst = 1'b0;
        bit_vld = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [8:0] ex_in;
        logic [8:0] ex_out;
        void'($urandom(32'h0000_5eed));
        ex_in  = 9'b011011100;
        ex_out = 9'b001111010;

        do_reset(2);
        // R3: reset state, idle output low
        check("R3 reset idle", detect_o, 1'b0);

        // R5: worked example
        for (int i = 8; i >= 0; i--) step_exp(ex_in[i], ex_out[i], "R5 example");

        // R2: three ones in a row
        do_reset(1);
        step_exp(1'b1, 1'b0, "R3 first one after reset");
        step_exp(1'b1, 1'b1, "R3 second one after reset");
        step_exp(1'b1, 1'b0, "R2 three ones");
        step_exp(1'b1, 1'b0, "R2 three ones again");

        // R4: gaps keep history, output low while idle
        step_exp(1'b0, 1'b1, "R1 window 1,1,0");
        step(1'b1, 1'b0, "R4 idle with bit high");
        step(1'b1, 1'b0, "R4 idle with bit high");
        step_exp(1'b0, 1'b0, "R4 history held across gap");
        step(1'b0, 1'b0, "R4 idle");
        step_exp(1'b1, 1'b0, "R6 oldest bit dropped");
        step_exp(1'b1, 1'b1, "R6 window 0,1,1");

        // R7: reset mid-stream after ones
        do_reset(1);
        step_exp(1'b0, 1'b0, "R7 zero after mid reset");
        step_exp(1'b1, 1'b0, "R7 history cleared");

        // R1/R4/R6/R7: random stream with gaps and occasional resets
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 300) == 0) begin
                do_reset(1 + ($urandom % 2));
                step(1'b1, 1'b1, "R7 random post-reset");
            end else begin
                step(1'($urandom % 2), 1'(($urandom % 4) != 0), "R1 random window");
            end
        end

        finish_run();
    end
endmodule